// File: doc/BRIEF.md
# Serial Port Register Front End

This block is the byte-wide register side of a simple serial port. A processor reaches it through a 6-bit address window. It can program two mode registers that share one address, read a status byte and an interrupt status byte, set an interrupt mask, and issue commands. One command byte holds three independent fields: a general action, a transmitter enable or disable, and a receiver enable or disable. Transmitted bytes leave on a one-cycle valid pulse. Received bytes, and break events from the line side, enter a small receive queue that the processor drains by reading the data offset.

One level-sensitive interrupt line is raised whenever an interrupt status bit is also enabled in the mask. The receive interrupt source can be switched between "data available" and "queue full" by a bit in the first mode register. Serial bit timing, baud generation and break generation sit outside this block.

Top module: `serial_port_regs`

## Requirements
- R1: Only offsets 0x00, 0x04, 0x0C and 0x14 can read back non-zero. Offsets 0x10, 0x18 and 0x1C, and every other offset, read 0. Writes to 0x04, to 0x10 and to any offset that is not 0x00, 0x08, 0x0C or 0x14 change nothing.
- R2: A write at 0x00 stores into the mode register chosen by the pointer and then points the pointer at the second mode register. A read at 0x00 returns the selected mode register and leaves the pointer where it is.
- R3: The status byte at 0x04 has bit0 = receive data available, bit1 = receive queue full, bit2 = transmitter enabled (ready) and bit3 = transmit buffer empty. Bits 7:4 read 0.
- R4: Command bits [6:4] select a general action. 1 points the mode pointer at the first register. 2 disables the receiver and empties the queue. 3 disables the transmitter and marks the buffer empty. 5 clears the break flag. 0, 4, 6 and 7 do nothing.
- R5: Command bits [3:2] control the transmitter and bits [1:0] control the receiver: 1 enables, 2 disables, 3 is ignored. The fields act in this order: general action, then transmitter, then receiver.
- R6: A write at 0x0C with the transmitter enabled sends the byte: `txValid` is high with the byte on `txData` for exactly the one cycle after the write, and the buffer stays empty. With the transmitter disabled the byte is held and the buffer is marked not empty. A later transmitter enable sends the held byte. Only a write at 0x0C or a command write can start a send.
- R7: The receive queue holds FIFO_DEPTH bytes (4 by default). `rxAccept` is high when the receiver is enabled and the queue is not full. A byte presented while `rxAccept` is low is dropped. A read at 0x0C returns the oldest byte and removes it, and a read of an empty queue returns 0.
- R8: A `breakIn` pulse sets the break flag and enqueues a 0 byte, even when the receiver is disabled. When the queue is full, the 0 byte replaces the newest entry.
- R9: The interrupt status at 0x14 has bit0 = transmitter ready and bit2 = break flag. Bit1 is queue full when bit 6 of the first mode register is set, and data available otherwise.
- R10: `irq` is high exactly when the interrupt status ANDed with the mask written at 0x14 is non-zero. It follows a mask write from the cycle after that write.
- R11: After reset, both mode registers, the mask and the interrupt status are 0, the status byte is 0x08, both directions are disabled, the mode pointer selects the first register, and `irq`, `txValid` and `rxAccept` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 6 | Register offset |
| busWrEn | input | 1 | Write strobe, one cycle per access |
| busWrData | input | 8 | Write data |
| busRdEn | input | 1 | Read strobe; a read at 0x0C removes a byte |
| busRdData | output | 8 | Read data, valid in the cycle of busRdEn |
| rxValid | input | 1 | Received byte present |
| rxData | input | 8 | Received byte |
| rxAccept | output | 1 | Receiver enabled and queue not full |
| breakIn | input | 1 | Break detected on the line, one-cycle pulse |
| txValid | output | 1 | Transmitted byte valid, one-cycle pulse |
| txData | output | 8 | Transmitted byte |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions assume a single bus master that never raises read and write strobes in the same cycle. They also assume that `breakIn` and a command write clearing the break flag never fall in the same cycle. The bench drives every access through one task at a time, so the strobes are always mutually exclusive, and it issues break pulses only while the bus is idle. A sweep over all 128 command values starts from the same prepared state each time. That state has a held transmit byte, a partly filled queue, the break flag set and the mode pointer advanced.

// File: rtl/serial_port_pkg.sv
package serial_port_pkg;

  localparam int DATA_W = 8;
  localparam int ADDR_W = 6;

  localparam logic [ADDR_W-1:0] OFF_MODE   = 6'h00;
  localparam logic [ADDR_W-1:0] OFF_STATUS = 6'h04;
  localparam logic [ADDR_W-1:0] OFF_CMD    = 6'h08;
  localparam logic [ADDR_W-1:0] OFF_DATA   = 6'h0C;
  localparam logic [ADDR_W-1:0] OFF_PORT   = 6'h10;
  localparam logic [ADDR_W-1:0] OFF_INT    = 6'h14;
  localparam logic [ADDR_W-1:0] OFF_RATE1  = 6'h18;
  localparam logic [ADDR_W-1:0] OFF_RATE2  = 6'h1C;

  // bit in the first mode register that picks the receive interrupt source
  localparam int MODE_RXSEL_BIT = 6;

  typedef enum logic [2:0] {
    MISC_NONE     = 3'd0,
    MISC_PTR_RST  = 3'd1,
    MISC_RX_RST   = 3'd2,
    MISC_TX_RST   = 3'd3,
    MISC_ERR_RST  = 3'd4,
    MISC_BRK_CLR  = 3'd5,
    MISC_BRK_ON   = 3'd6,
    MISC_BRK_OFF  = 3'd7
  } miscOp_e;

  typedef enum logic [1:0] {
    ENA_KEEP = 2'd0,
    ENA_ON   = 2'd1,
    ENA_OFF  = 2'd2,
    ENA_RSVD = 2'd3
  } enaOp_e;

  typedef enum logic [2:0] {
    RD_ZERO,
    RD_MODE,
    RD_STATUS,
    RD_DATA,
    RD_INT
  } rdSel_e;

  typedef struct packed {
    logic    wrMode;
    logic    wrMask;
    logic    wrTx;
    logic    wrCmd;
    logic    popRx;
    miscOp_e misc;
    enaOp_e  txOp;
    enaOp_e  rxOp;
    rdSel_e  rdSel;
  } ctrlStrobes_t;

endpackage

// File: rtl/serial_port_ctrl.sv
module serial_port_ctrl
  import serial_port_pkg::*;
(
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [DATA_W-1:0] busWrData,
  output ctrlStrobes_t      strobes
);

  always_comb begin
    strobes        = '0;
    strobes.misc   = MISC_NONE;
    strobes.txOp   = ENA_KEEP;
    strobes.rxOp   = ENA_KEEP;
    strobes.rdSel  = RD_ZERO;

    if (busWrEn) begin
      unique case (busAddr)
        OFF_MODE: strobes.wrMode = 1'b1;
        OFF_DATA: strobes.wrTx   = 1'b1;
        OFF_INT:  strobes.wrMask = 1'b1;
        OFF_CMD: begin
          strobes.wrCmd = 1'b1;
          strobes.misc  = miscOp_e'(busWrData[6:4]);
          strobes.txOp  = enaOp_e'(busWrData[3:2]);
          strobes.rxOp  = enaOp_e'(busWrData[1:0]);
        end
        default: ;
      endcase
    end

    if (busRdEn) begin
      unique case (busAddr)
        OFF_MODE:   strobes.rdSel = RD_MODE;
        OFF_STATUS: strobes.rdSel = RD_STATUS;
        OFF_DATA: begin
          strobes.rdSel = RD_DATA;
          strobes.popRx = 1'b1;
        end
        OFF_INT:    strobes.rdSel = RD_INT;
        // port change and both rate registers fall through to zero
        default:    strobes.rdSel = RD_ZERO;
      endcase
    end
  end

endmodule

// File: rtl/serial_port_dp.sv
module serial_port_dp
  import serial_port_pkg::*;
#(
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxData,
  output logic              rxAccept,
  input  logic              breakIn,
  output logic              txValid,
  output logic [DATA_W-1:0] txData,
  output logic              irq
);

  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
  localparam int IDX_W = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FIFO_DEPTH);

  logic [DATA_W-1:0] modeReg [2];
  logic              modePtr;
  logic [DATA_W-1:0] maskReg;
  logic [DATA_W-1:0] txBuf;
  logic              txEn, txEmpty, rxEn, brkFlag;
  logic [CNT_W-1:0]  rxCnt;
  logic [DATA_W-1:0] rxQ [FIFO_DEPTH];

  logic [DATA_W-1:0] nTxBuf;
  logic              nModePtr, nTxEn, nTxEmpty, nRxEn, nBrk, doSend, doFlush;
  logic [CNT_W-1:0]  nCnt;
  logic [DATA_W-1:0] nQ [FIFO_DEPTH];

  logic              rxAvail, rxFull;
  logic [DATA_W-1:0] statusVal, intVal;

  assign rxAvail  = (rxCnt != '0);
  assign rxFull   = (rxCnt == FULL_CNT);
  assign rxAccept = rxEn && !rxFull;

  assign statusVal = {4'b0000, txEmpty, txEn, rxFull, rxAvail};
  assign intVal    = {5'b00000, brkFlag,
                      (modeReg[0][MODE_RXSEL_BIT] ? rxFull : rxAvail), txEn};
  assign irq       = |(intVal & maskReg);

  always_comb begin
    unique case (strobes.rdSel)
      RD_MODE:   busRdData = modeReg[modePtr];
      RD_STATUS: busRdData = statusVal;
      RD_DATA:   busRdData = rxAvail ? rxQ[0] : '0;
      RD_INT:    busRdData = intVal;
      default:   busRdData = '0;
    endcase
  end

  // next-state, applied in the order the actions take effect
  always_comb begin
    nModePtr = modePtr;
    nTxEn    = txEn;
    nTxEmpty = txEmpty;
    nTxBuf   = txBuf;
    nRxEn    = rxEn;
    nBrk     = brkFlag;
    nCnt     = rxCnt;
    nQ       = rxQ;
    doSend   = 1'b0;
    doFlush  = 1'b0;

    if (strobes.wrMode) nModePtr = 1'b1;

    if (strobes.wrTx) begin
      nTxBuf   = busWrData;
      nTxEmpty = 1'b0;
      if (txEn) begin
        doSend   = 1'b1;
        nTxEmpty = 1'b1;
      end
    end

    if (strobes.wrCmd) begin
      unique case (strobes.misc)
        MISC_PTR_RST: nModePtr = 1'b0;
        MISC_RX_RST: begin
          nRxEn   = 1'b0;
          doFlush = 1'b1;
        end
        MISC_TX_RST: begin
          nTxEn    = 1'b0;
          nTxEmpty = 1'b1;
        end
        MISC_BRK_CLR: nBrk = 1'b0;
        default: ;
      endcase

      unique case (strobes.txOp)
        ENA_ON: begin
          nTxEn = 1'b1;
          if (!nTxEmpty) begin
            doSend   = 1'b1;
            nTxEmpty = 1'b1;
          end
        end
        ENA_OFF: nTxEn = 1'b0;
        default: ;
      endcase

      unique case (strobes.rxOp)
        ENA_ON:  nRxEn = 1'b1;
        ENA_OFF: nRxEn = 1'b0;
        default: ;
      endcase
    end

    if (strobes.popRx && rxAvail) begin
      for (int i = 0; i < FIFO_DEPTH - 1; i++) nQ[i] = nQ[i + 1];
      nCnt = nCnt - 1'b1;
    end

    if (breakIn) begin
      nBrk = 1'b1;
      if (nCnt == FULL_CNT) nCnt = nCnt - 1'b1;
      nQ[nCnt[IDX_W-1:0]] = '0;
      nCnt = nCnt + 1'b1;
    end else if (rxValid && rxAccept) begin
      nQ[nCnt[IDX_W-1:0]] = rxData;
      nCnt = nCnt + 1'b1;
    end

    if (doFlush) nCnt = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg[0] <= '0;
      modeReg[1] <= '0;
      modePtr    <= 1'b0;
      maskReg    <= '0;
      txBuf      <= '0;
      txEn       <= 1'b0;
      txEmpty    <= 1'b1;
      rxEn       <= 1'b0;
      brkFlag    <= 1'b0;
      rxCnt      <= '0;
      txValid    <= 1'b0;
      txData     <= '0;
    end else begin
      if (strobes.wrMode) modeReg[modePtr] <= busWrData;
      if (strobes.wrMask) maskReg <= busWrData;
      modePtr <= nModePtr;
      txBuf   <= nTxBuf;
      txEn    <= nTxEn;
      txEmpty <= nTxEmpty;
      rxEn    <= nRxEn;
      brkFlag <= nBrk;
      rxCnt   <= nCnt;
      txValid <= doSend;
      if (doSend) txData <= nTxBuf;
    end
  end

  generate
    for (genvar g = 0; g < FIFO_DEPTH; g++) begin : g_slot
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) rxQ[g] <= '0;
        else       rxQ[g] <= nQ[g];
      end
    end
  endgenerate

endmodule

// File: rtl/serial_port_regs.sv
module serial_port_regs
  import serial_port_pkg::*;
#(
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busRdEn,
  output logic [DATA_W-1:0] busRdData,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxData,
  output logic              rxAccept,
  input  logic              breakIn,
  output logic              txValid,
  output logic [DATA_W-1:0] txData,
  output logic              irq
);

  ctrlStrobes_t strobes;

  serial_port_ctrl u_ctrl (
    .busAddr   (busAddr),
    .busWrEn   (busWrEn),
    .busRdEn   (busRdEn),
    .busWrData (busWrData),
    .strobes   (strobes)
  );

  serial_port_dp #(.FIFO_DEPTH(FIFO_DEPTH)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .rxValid   (rxValid),
    .rxData    (rxData),
    .rxAccept  (rxAccept),
    .breakIn   (breakIn),
    .txValid   (txValid),
    .txData    (txData),
    .irq       (irq)
  );

endmodule

// File: rtl/serial_port_regs_chk.sv
module serial_port_regs_chk (
  input logic       clk,
  input logic       rstN,
  input logic [5:0] busAddr,
  input logic       busWrEn,
  input logic [7:0] busWrData,
  input logic       busRdEn,
  input logic [7:0] busRdData,
  input logic       rxAccept,
  input logic       txValid,
  input logic       irq
);

  // R10: a zero mask silences the interrupt on the following cycle
  p_mask_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == 6'h14 && busWrData == 8'h00) |=> !irq);

  // R6: a send is only ever caused by a data write or a command write
  p_tx_source_r6: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> $past(busWrEn && (busAddr == 6'h0C || busAddr == 6'h08)));

  // R5: a transmitter disable command never sends
  p_tx_off_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == 6'h08 && busWrData[3:2] == 2'd2) |=> !txValid);

  // R4: receiver reset without re-enable leaves the receiver closed
  p_rx_reset_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == 6'h08 && busWrData[6:4] == 3'd2 && busWrData[1:0] != 2'd1)
    |=> !rxAccept);

  // R1: both rate registers and the port change register read zero
  p_fixed_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && (busAddr == 6'h18 || busAddr == 6'h1C || busAddr == 6'h10))
    |-> busRdData == 8'h00);

endmodule

bind serial_port_regs serial_port_regs_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busAddr   (busAddr),
  .busWrEn   (busWrEn),
  .busWrData (busWrData),
  .busRdEn   (busRdEn),
  .busRdData (busRdData),
  .rxAccept  (rxAccept),
  .txValid   (txValid),
  .irq       (irq)
);

// File: tb/serial_port_regs_test.sv
`timescale 1ns/1ps
module serial_port_regs_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [5:0] busAddr = '0;
  logic       busWrEn = 1'b0;
  logic [7:0] busWrData = '0;
  logic       busRdEn = 1'b0;
  logic [7:0] busRdData;
  logic       rxValid = 1'b0;
  logic [7:0] rxData = '0;
  logic       rxAccept;
  logic       breakIn = 1'b0;
  logic       txValid;
  logic [7:0] txData;
  logic       irq;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  serial_port_regs uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdEn(busRdEn), .busRdData(busRdData),
    .rxValid(rxValid), .rxData(rxData), .rxAccept(rxAccept),
    .breakIn(breakIn), .txValid(txValid), .txData(txData), .irq(irq)
  );

  task automatic check(input logic [7:0] got, input logic [7:0] exp, input string tag);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(posedge clk); #1;
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    #1 d = busRdData;
    @(posedge clk); #1;
    busRdEn = 1'b0;
  endtask

  task automatic pushRx(input logic [7:0] d);
    @(negedge clk);
    rxData = d; rxValid = 1'b1;
    @(posedge clk); #1;
    rxValid = 1'b0;
  endtask

  task automatic pulseBreak();
    @(negedge clk);
    breakIn = 1'b1;
    @(posedge clk); #1;
    breakIn = 1'b0;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] v;

    // ---- R11 reset state
    doReset();
    rd(6'h04, v); check(v, 8'h08, "R11 status after reset");
    rd(6'h14, v); check(v, 8'h00, "R11 int status after reset");
    rd(6'h00, v); check(v, 8'h00, "R11 mode after reset");
    check({7'd0, irq}, 8'd0, "R11 irq after reset");
    check({7'd0, rxAccept}, 8'd0, "R11 rxAccept after reset");
    check({7'd0, txValid}, 8'd0, "R11 txValid after reset");

    // ---- R1 / R2 full address sweep
    wr(6'h00, 8'h1A);
    wr(6'h00, 8'h77);
    wr(6'h08, 8'h04);
    for (int a = 0; a < 64; a++) begin
      logic [7:0] e;
      case (a)
        'h00: e = 8'h77;
        'h04: e = 8'h0C;
        'h14: e = 8'h01;
        default: e = 8'h00;
      endcase
      rd(6'(a), v); check(v, e, $sformatf("R1 read sweep offset %0h", a));
    end
    for (int a = 0; a < 64; a++) begin
      if (a == 'h00 || a == 'h08 || a == 'h0C || a == 'h14) continue;
      wr(6'(a), 8'hFF);
      check({7'd0, txValid}, 8'd0, "R1 ignored write no send");
    end
    rd(6'h04, v); check(v, 8'h0C, "R1 status unchanged by ignored writes");
    rd(6'h14, v); check(v, 8'h01, "R1 int status unchanged by ignored writes");
    rd(6'h00, v); check(v, 8'h77, "R2 pointer held across reads");
    check({7'd0, irq}, 8'd0, "R1 mask unchanged by ignored writes");
    wr(6'h08, 8'h10);
    rd(6'h00, v); check(v, 8'h1A, "R2 pointer reset selects first mode");
    rd(6'h00, v); check(v, 8'h1A, "R2 read does not advance pointer");

    // ---- R4 R5 sweep over every command value from a prepared state
    for (int c = 0; c < 128; c++) begin
      int ptr, txEn, empty, rxEn, cnt, brk, sent;
      doReset();
      wr(6'h00, 8'h1A);
      wr(6'h08, 8'h01);
      pushRx(8'h31);
      pushRx(8'h32);
      pulseBreak();
      wr(6'h0C, 8'hC3);
      if (c == 0) check({7'd0, txValid}, 8'd0, "R6 disabled write holds byte");
      ptr = 1; txEn = 0; empty = 0; rxEn = 1; cnt = 3; brk = 1; sent = 0;
      case ((c >> 4) & 7)
        1: ptr = 0;
        2: begin rxEn = 0; cnt = 0; end
        3: begin txEn = 0; empty = 1; end
        5: brk = 0;
        default: ;
      endcase
      case ((c >> 2) & 3)
        1: begin txEn = 1; if (empty == 0) begin sent = 1; empty = 1; end end
        2: txEn = 0;
        default: ;
      endcase
      case (c & 3)
        1: rxEn = 1;
        2: rxEn = 0;
        default: ;
      endcase
      wr(6'h08, 8'(c));
      check({7'd0, txValid}, 8'(sent), $sformatf("R5 cmd %0h send", c));
      if (sent != 0) check(txData, 8'hC3, $sformatf("R6 cmd %0h held byte", c));
      rd(6'h04, v);
      check(v, 8'((empty << 3) | (txEn << 2) | ((cnt == 4) << 1) | (cnt != 0)),
            $sformatf("R4 cmd %0h status", c));
      rd(6'h14, v);
      check(v, 8'((brk << 2) | ((cnt != 0) << 1) | txEn), $sformatf("R9 cmd %0h int status", c));
      rd(6'h00, v);
      check(v, (ptr != 0) ? 8'h00 : 8'h1A, $sformatf("R4 cmd %0h mode pointer", c));
      check({7'd0, rxAccept}, 8'(rxEn), $sformatf("R5 cmd %0h receiver enable", c));
      check({7'd0, irq}, 8'd0, "R10 masked irq stays low");
    end

    // ---- R7 R8 receive queue
    doReset();
    pushRx(8'h99);
    rd(6'h04, v); check(v, 8'h08, "R7 disabled receiver drops byte");
    wr(6'h08, 8'h05);
    pushRx(8'h11); pushRx(8'h22); pushRx(8'h33); pushRx(8'h44);
    check({7'd0, rxAccept}, 8'd0, "R7 full queue refuses");
    rd(6'h04, v); check(v, 8'h0F, "R3 status with full queue");
    pushRx(8'h55);
    pulseBreak();
    rd(6'h14, v); check(v, 8'h07, "R8 break flag set");
    rd(6'h0C, v); check(v, 8'h11, "R7 pop first");
    check({7'd0, rxAccept}, 8'd1, "R7 accept after pop");
    rd(6'h0C, v); check(v, 8'h22, "R7 pop second");
    rd(6'h0C, v); check(v, 8'h33, "R7 pop third");
    rd(6'h0C, v); check(v, 8'h00, "R8 break overwrote newest");
    rd(6'h0C, v); check(v, 8'h00, "R7 empty read returns zero");
    rd(6'h04, v); check(v, 8'h0C, "R7 status after drain");
    wr(6'h08, 8'h02);
    pulseBreak();
    rd(6'h04, v); check(v, 8'h0D, "R8 break enqueues with receiver off");
    rd(6'h0C, v); check(v, 8'h00, "R8 break byte is zero");
    wr(6'h08, 8'h01);

    // ---- R9 receive interrupt source select
    wr(6'h08, 8'h10);
    wr(6'h00, 8'h40);
    pushRx(8'hA1);
    rd(6'h14, v); check(v, 8'h05, "R9 full-select with one byte");
    pushRx(8'hA2); pushRx(8'hA3); pushRx(8'hA4);
    rd(6'h14, v); check(v, 8'h07, "R9 full-select with full queue");

    // ---- R10 interrupt mask
    wr(6'h14, 8'h02); check({7'd0, irq}, 8'd1, "R10 rx source unmasked");
    wr(6'h08, 8'h50);
    wr(6'h14, 8'h04); check({7'd0, irq}, 8'd0, "R10 break cleared");
    rd(6'h0C, v); check(v, 8'hA1, "R7 oldest after refill");
    wr(6'h14, 8'h02); check({7'd0, irq}, 8'd0, "R10 no longer full");
    wr(6'h14, 8'h01); check({7'd0, irq}, 8'd1, "R10 tx ready unmasked");
    wr(6'h08, 8'h08); check({7'd0, irq}, 8'd0, "R10 tx disabled drops irq");
    wr(6'h14, 8'h00); check({7'd0, irq}, 8'd0, "R10 zero mask");

    // ---- R6 transmit path
    doReset();
    wr(6'h08, 8'h04);
    wr(6'h0C, 8'hA5);
    check({7'd0, txValid}, 8'd1, "R6 enabled write sends");
    check(txData, 8'hA5, "R6 sent data");
    @(posedge clk); #1;
    check({7'd0, txValid}, 8'd0, "R6 pulse lasts one cycle");
    rd(6'h04, v); check(v, 8'h0C, "R6 buffer empty after send");
    wr(6'h08, 8'h08);
    wr(6'h0C, 8'h5C);
    rd(6'h04, v); check(v, 8'h00, "R3 held byte clears empty");
    wr(6'h08, 8'h0F);
    check({7'd0, txValid}, 8'd0, "R5 reserved fields ignored");
    rd(6'h04, v); check(v, 8'h00, "R5 reserved fields keep state");
    wr(6'h08, 8'h04);
    check({7'd0, txValid}, 8'd1, "R6 enable sends held byte");
    check(txData, 8'h5C, "R6 held byte data");
    wr(6'h08, 8'h08);
    wr(6'h0C, 8'h6D);
    wr(6'h08, 8'h30);
    rd(6'h04, v); check(v, 8'h08, "R4 transmitter reset marks empty");
    wr(6'h08, 8'h04);
    check({7'd0, txValid}, 8'd0, "R4 transmitter reset discards byte");

    summary();
    $finish;
  end

endmodule